// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Controller

This block watches a set of asynchronous event lines, brings each one into the local clock domain, and detects rising and falling transitions on it. Software chooses, line by line, which transition directions count. A qualifying transition latches a sticky pending flag for that line. If the line is also unmasked, the block raises a single-cycle pulse on the matching interrupt output.

Software reaches the block through a 32-bit register port with byte addresses inside a 1 KiB window. The port has a write strobe, and reads are combinational from the address. Six word registers are mapped: an interrupt enable mask, an event mask kept only as storage, rising and falling edge selects, a software trigger kept only as storage, and the pending flags. A pending flag is cleared by writing a 1 to its bit.

Top module: `ext_edge_irq`

## Requirements
- R1: After reset, all six registers read as zero and no interrupt output is high.
- R2: The interrupt enable (offset 0x00), event mask (0x04), rising select (0x08), falling select (0x0C) and software trigger (0x10) registers each read back the full 32-bit value last written to them.
- R3: A low-to-high transition on line i, with bit i of the rising select set, sets bit i of the pending register (offset 0x14). The bit becomes visible after the third rising clock edge following the input change: two synchroniser stages, then the latch.
- R4: A high-to-low transition on line i, with bit i of the falling select set, sets pending bit i with the same latency.
- R5: A transition whose direction is not selected for its line leaves that pending bit unchanged.
- R6: A pending bit is set even when its interrupt enable bit is 0, and that line then produces no output pulse.
- R7: For a line whose interrupt enable bit is 1, output i is high for exactly one cycle. That cycle follows the same clock edge that sets the pending bit, and the output falls on the next edge if no further edge qualifies.
- R8: A write to offset 0x14 clears every pending bit whose data bit is 1 and leaves bits written with 0 unchanged.
- R9: If a qualifying edge and a write-1-to-clear of the same pending bit take effect on the same clock edge, the bit ends at 1.
- R10: Offsets that are not multiples of 4, and word offsets from 0x18 up to 0x3FC, read as zero, and writes to them change no register.
- R11: Writing the software trigger register sets no pending bit and raises no output.
- R12: Pending bits 31..16 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 10 | Byte address within the register window |
| regWrEn | input | 1 | Write strobe, one write per cycle it is high |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| evIn | input | 16 | Asynchronous event input lines |
| irqPulse | output | 16 | Per-line single-cycle interrupt pulses |

## Verification
The bench sets each pending bit with edges in both directions, with mixed select patterns and with deselected directions. A design that confused rising and falling, or that latched unselected transitions, would show the wrong pending word. Masked lines are driven to catch a block that gates the latch with the mask, which would lose the flag, or that leaks a pulse. The bench times a write-1-to-clear to land on the same edge as a qualifying transition; a design that lets the clear win drops an interrupt. Further tests cover partial clears, unmapped and misaligned writes, and writes to the software trigger. These catch designs that clear the whole register, that alias the window, or that treat the trigger as a real event source.

// File: rtl/ext_edge_irq_pkg.sv
package ext_edge_irq_pkg;

  // Register selected by the current address
  typedef enum logic [2:0] {
    SEL_MASK   = 3'd0,
    SEL_EVMASK = 3'd1,
    SEL_RISE   = 3'd2,
    SEL_FALL   = 3'd3,
    SEL_SWTRIG = 3'd4,
    SEL_PEND   = 3'd5,
    SEL_NONE   = 3'd7
  } regSel_e;

  // Write strobes from control to datapath
  typedef struct packed {
    logic wrMask;
    logic wrEvMask;
    logic wrRise;
    logic wrFall;
    logic wrSwTrig;
    logic wrPendClr;
  } regStrobe_t;

endpackage

// File: rtl/ext_edge_irq_ctrl.sv
module ext_edge_irq_ctrl
  import ext_edge_irq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        strobes,
  output regSel_e           rdSel
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              aligned;

  assign wordIdx = regAddr[ADDR_W-1:2];
  assign aligned = (regAddr[1:0] == 2'b00);

  always_comb begin
    rdSel = SEL_NONE;
    if (aligned) begin
      case (wordIdx)
        WORD_W'(0): rdSel = SEL_MASK;
        WORD_W'(1): rdSel = SEL_EVMASK;
        WORD_W'(2): rdSel = SEL_RISE;
        WORD_W'(3): rdSel = SEL_FALL;
        WORD_W'(4): rdSel = SEL_SWTRIG;
        WORD_W'(5): rdSel = SEL_PEND;
        default:    rdSel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    strobes = '0;
    if (regWrEn) begin
      case (rdSel)
        SEL_MASK:   strobes.wrMask    = 1'b1;
        SEL_EVMASK: strobes.wrEvMask  = 1'b1;
        SEL_RISE:   strobes.wrRise    = 1'b1;
        SEL_FALL:   strobes.wrFall    = 1'b1;
        SEL_SWTRIG: strobes.wrSwTrig  = 1'b1;
        SEL_PEND:   strobes.wrPendClr = 1'b1;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/ext_edge_irq_line.sv
module ext_edge_irq_line (
  input  logic clk,
  input  logic rstN,
  input  logic evRaw,
  input  logic riseEn,
  input  logic fallEn,
  input  logic maskEn,
  output logic edgeHit,
  output logic pulseOut
);
  logic syncA;
  logic syncB;
  logic prevB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      prevB    <= 1'b0;
      pulseOut <= 1'b0;
    end else begin
      syncA    <= evRaw;
      syncB    <= syncA;
      prevB    <= syncB;
      pulseOut <= edgeHit & maskEn;
    end
  end

  assign edgeHit = (riseEn & syncB & ~prevB) | (fallEn & ~syncB & prevB);

endmodule

// File: rtl/ext_edge_irq_dp.sv
module ext_edge_irq_dp
  import ext_edge_irq_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobes,
  input  regSel_e           rdSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LINES-1:0]  evIn,
  output logic [DATA_W-1:0] rdData,
  output logic [LINES-1:0]  irqPulse
);
  logic [DATA_W-1:0] maskQ;
  logic [DATA_W-1:0] evMaskQ;
  logic [DATA_W-1:0] riseQ;
  logic [DATA_W-1:0] fallQ;
  logic [DATA_W-1:0] swTrigQ;
  logic [LINES-1:0]  pendQ;
  logic [LINES-1:0]  hitVec;
  logic [LINES-1:0]  clrVec;
  logic [DATA_W-1:0] pendExt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ   <= '0;
      evMaskQ <= '0;
      riseQ   <= '0;
      fallQ   <= '0;
      swTrigQ <= '0;
    end else begin
      if (strobes.wrMask)   maskQ   <= wrData;
      if (strobes.wrEvMask) evMaskQ <= wrData;
      if (strobes.wrRise)   riseQ   <= wrData;
      if (strobes.wrFall)   fallQ   <= wrData;
      if (strobes.wrSwTrig) swTrigQ <= wrData;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < LINES; gi++) begin : g_line
      ext_edge_irq_line u_line (
        .clk     (clk),
        .rstN    (rstN),
        .evRaw   (evIn[gi]),
        .riseEn  (riseQ[gi]),
        .fallEn  (fallQ[gi]),
        .maskEn  (maskQ[gi]),
        .edgeHit (hitVec[gi]),
        .pulseOut(irqPulse[gi])
      );
    end
  endgenerate

  assign clrVec = strobes.wrPendClr ? wrData[LINES-1:0] : '0;

  // A new edge takes priority over a clear of the same bit
  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= (pendQ & ~clrVec) | hitVec;
  end

  always_comb begin
    pendExt             = '0;
    pendExt[LINES-1:0]  = pendQ;
  end

  always_comb begin
    case (rdSel)
      SEL_MASK:   rdData = maskQ;
      SEL_EVMASK: rdData = evMaskQ;
      SEL_RISE:   rdData = riseQ;
      SEL_FALL:   rdData = fallQ;
      SEL_SWTRIG: rdData = swTrigQ;
      SEL_PEND:   rdData = pendExt;
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/ext_edge_irq.sv
module ext_edge_irq
  import ext_edge_irq_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [LINES-1:0]  evIn,
  output logic [LINES-1:0]  irqPulse
);
  regStrobe_t strobes;
  regSel_e    rdSel;

  ext_edge_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .strobes(strobes),
    .rdSel  (rdSel)
  );

  ext_edge_irq_dp #(.LINES(LINES), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .rdSel   (rdSel),
    .wrData  (regWrData),
    .evIn    (evIn),
    .rdData  (regRdData),
    .irqPulse(irqPulse)
  );

endmodule

// File: rtl/ext_edge_irq_chk.sv
module ext_edge_irq_chk #(
  parameter int LINES  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic [LINES-1:0]  irqPulse,
  input logic [DATA_W-1:0] maskQ,
  input logic [LINES-1:0]  pendQ
);
  localparam logic [ADDR_W-1:0] PEND_OFS = ADDR_W'(20);
  localparam logic [ADDR_W-1:0] LAST_OFS = ADDR_W'(20);

  // R6
  masked_no_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse & ~$past(maskQ[LINES-1:0])) == '0);

  // R7
  pulse_has_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse & ~pendQ) == '0);

  // R8
  pend_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(pendQ) & ~pendQ)) |-> $past(regWrEn && regAddr == PEND_OFS));

  // R2
  mask_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == '0) |=> (maskQ == $past(regWrData)));

  // R10
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr > LAST_OFS) |=> $stable(maskQ));

endmodule

bind ext_edge_irq ext_edge_irq_chk #(.LINES(LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regWrEn  (regWrEn),
  .regWrData(regWrData),
  .irqPulse (irqPulse),
  .maskQ    (u_dp.maskQ),
  .pendQ    (u_dp.pendQ)
);

// File: tb/ext_edge_irq_test.sv
module ext_edge_irq_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [15:0] evIn = '0;
  logic [15:0] irqPulse;

  int checks = 0;
  int fails = 0;
  bit doneFlag = 0;

  always #5 clk = ~clk;

  ext_edge_irq uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .evIn(evIn), .irqPulse(irqPulse)
  );

  typedef struct packed {
    logic [15:0] rise;
    logic [15:0] fall;
    logic [15:0] mask;
    logic [15:0] evA;
    logic [15:0] evB;
    logic [15:0] pend;
    logic [15:0] pulse;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000, 16'h00FF, 16'h00FF, 16'h00FF},
    '{16'h0000, 16'hFFFF, 16'h0F0F, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0F0F},
    '{16'h00F0, 16'h0F00, 16'hFFFF, 16'h0F00, 16'h00F0, 16'h0FF0, 16'h0FF0},
    '{16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000},
    '{16'hAAAA, 16'h5555, 16'h0000, 16'h0000, 16'hFFFF, 16'hAAAA, 16'h0000},
    '{16'hFFFF, 16'hFFFF, 16'h8001, 16'h5A5A, 16'hA5A5, 16'hFFFF, 16'h8001}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic settle(input logic [15:0] ev);
    @(negedge clk);
    evIn = ev;
    repeat (5) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int i = 0; i < 6; i++) begin
      rd(10'(i * 4), v);
      chk("R1 register reset", v, 32'h0);
    end
    chk("R1 outputs at reset", {16'h0, irqPulse}, 32'h0);

    // R2 plain storage
    wr(10'h000, 32'hDEAD_0001); wr(10'h004, 32'hBEEF_0002);
    wr(10'h008, 32'hCAFE_0000); wr(10'h00C, 32'h1234_0000);
    wr(10'h010, 32'hFFFF_FFFF);
    rd(10'h000, v); chk("R2 mask", v, 32'hDEAD_0001);
    rd(10'h004, v); chk("R2 event mask", v, 32'hBEEF_0002);
    rd(10'h008, v); chk("R2 rise", v, 32'hCAFE_0000);
    rd(10'h00C, v); chk("R2 fall", v, 32'h1234_0000);
    rd(10'h010, v); chk("R2 swtrig", v, 32'hFFFF_FFFF);

    // R11 software trigger writes do not set pending
    wr(10'h000, 32'h0000_FFFF);
    wr(10'h010, 32'h0000_FFFF);
    repeat (3) @(negedge clk);
    chk("R11 no pulse", {16'h0, irqPulse}, 32'h0);
    rd(10'h014, v); chk("R11 no pending", v, 32'h0);

    // Vector table: R3 R4 R5 R6 R7
    foreach (VECS[k]) begin
      wr(10'h008, 32'h0); wr(10'h00C, 32'h0);
      settle(VECS[k].evA);
      wr(10'h014, 32'hFFFF_FFFF);
      wr(10'h008, {16'h0, VECS[k].rise});
      wr(10'h00C, {16'h0, VECS[k].fall});
      wr(10'h000, {16'h0, VECS[k].mask});
      @(negedge clk);
      evIn = VECS[k].evB;
      repeat (3) @(posedge clk);
      @(negedge clk);
      regAddr = 10'h014;
      #1;
      chk("R3 R4 R5 R6 pending", regRdData, {16'h0, VECS[k].pend});
      chk("R7 pulse", {16'h0, irqPulse}, {16'h0, VECS[k].pulse});
      @(negedge clk);
      #1 chk("R7 pulse ends", {16'h0, irqPulse}, 32'h0);
    end

    // R12 upper pending bits read zero, R8 partial clear
    wr(10'h00C, 32'h0); wr(10'h008, 32'hFFFF_FFFF);
    settle(16'h0000);
    wr(10'h014, 32'hFFFF_FFFF);
    settle(16'hFFFF);
    rd(10'h014, v); chk("R12 pending upper zero", v, 32'h0000_FFFF);
    wr(10'h014, 32'h0000_00FF);
    rd(10'h014, v); chk("R8 partial clear", v, 32'h0000_FF00);

    // R9 set wins over simultaneous clear
    wr(10'h008, 32'h1); wr(10'h000, 32'h0);
    settle(16'h0000);
    wr(10'h014, 32'hFFFF_FFFF);
    @(negedge clk);
    evIn = 16'h0001;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    regAddr = 10'h014; regWrData = 32'h1; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    rd(10'h014, v); chk("R9 set beats clear", v, 32'h1);
    wr(10'h014, 32'h1);
    rd(10'h014, v); chk("R8 clear to zero", v, 32'h0);

    // R10 unmapped and misaligned accesses
    wr(10'h000, 32'h0000_1111);
    wr(10'h018, 32'hFFFF_FFFF); wr(10'h3FC, 32'hFFFF_FFFF); wr(10'h001, 32'hFFFF_FFFF);
    rd(10'h018, v); chk("R10 unmapped read", v, 32'h0);
    rd(10'h3FC, v); chk("R10 top read", v, 32'h0);
    rd(10'h002, v); chk("R10 misaligned read", v, 32'h0);
    rd(10'h000, v); chk("R10 mask untouched", v, 32'h0000_1111);
    rd(10'h004, v); chk("R10 event mask untouched", v, 32'hBEEF_0002);

    finishRun();
  end
endmodule